// File: doc/BRIEF.md
# Branch Trace Address Serializer

This block sends the destination address of each taken branch to an external debug probe. The output is a 4-bit data bus and an active-low frame strobe, both timed by the trace clock. When the CPU reports a branch, the block drives one header nibble and then the address, one nibble per cycle, least significant nibble first. The header tells the probe how many address nibbles follow.

To save pin bandwidth, the block drops the upper nibbles that match the last address it sent in full. The probe rebuilds those nibbles from its own copy of that address. A send that a newer branch cuts short never becomes the reference, because the probe never saw all of its nibbles. A newer branch always takes priority over an address that is still going out. When nothing is being sent, the bus carries a fixed idle pattern.

Top module: `trc_serializer`

## Requirements
- R1: When no transfer is in progress, including from reset onward, `tr_data` holds 4'b0011 and `tr_sync` is high.
- R2: A header nibble is 2'b10 followed by a 2-bit length code. Code 00 means 1 address nibble follows, 01 means 2, 10 means 4 and 11 means 8 (the full 32 bits).
- R3: The header is on the bus during the cycle right after the clock edge that samples `br_valid` high.
- R4: The address nibbles follow the header on consecutive cycles, least significant first: bits 3:0, then 7:4, and so on up to the coded length.
- R5: The length code is the shortest one for which every omitted upper address bit equals the same bit of the reference address.
- R6: The first branch after reset is always sent at full length (header 4'b1011).
- R7: The reference address becomes the new address only when its last nibble has been on the bus for a full cycle. A send that is cut short leaves the reference unchanged.
- R8: A branch sampled while a header or address nibble is on the bus stops that send. The header of the new branch appears in the next cycle.
- R9: `tr_sync` is low during the header and every address nibble. It returns high in the cycle after the last nibble.
- R10: Suppose a branch is sampled at the same edge that ends the cycle carrying the last nibble of a send. That send still counts as complete, and the new branch is compared against that send's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trc_clk | input | 1 | Trace clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch to a new destination is reported this cycle |
| br_addr | input | 32 | Branch destination address |
| tr_data | output | 4 | Trace nibble bus |
| tr_sync | output | 1 | Frame strobe, low while a header or address nibble is on the bus |

## Verification
The hardest case to reach from the ports is a new branch landing on the exact edge that ends the last nibble. Here the reference update and the new length choice happen in the same cycle. The bench reaches it by starting a 4-nibble send and launching the next branch at the falling edge where the fourth nibble is checked. It picks the second address so that it compresses to one nibble only if the interrupted send counts as complete. Sends pre-empted mid-address and during the header use second addresses that compress only against the older reference, which shows that a cut-short send is ignored.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int NIB_W = 4;
   localparam logic [3:0] IDLE_NIB = 4'b0011;
   localparam logic [1:0] HDR_TAG  = 2'b10;

   // Length code carried in the low two header bits; value k means 2**k nibbles.
   typedef enum logic [1:0] {
      SPAN_N1 = 2'd0,
      SPAN_N2 = 2'd1,
      SPAN_N4 = 2'd2,
      SPAN_N8 = 2'd3
   } span_e;

   function automatic int unsigned span_nibs(span_e s);
      return 32'd1 << s;
   endfunction
endpackage

// File: rtl/trc_len_sel.sv
module trc_len_sel
   import trc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] ref_i,
   input  logic              ref_ok_i,
   output span_e             span_o
);
   localparam int N_SHORT = 3;

   logic [N_SHORT-1:0] upper_eq;

   for (genvar g = 0; g < N_SHORT; g++) begin : g_cmp
      localparam int LO = NIB_W << g;
      assign upper_eq[g] = ref_ok_i && (addr_i[ADDR_W-1:LO] == ref_i[ADDR_W-1:LO]);
   end

   always_comb begin
      if (upper_eq[0])      span_o = SPAN_N1;
      else if (upper_eq[1]) span_o = SPAN_N2;
      else if (upper_eq[2]) span_o = SPAN_N4;
      else                  span_o = SPAN_N8;
   end
endmodule

// File: rtl/trc_ref.sv
module trc_ref #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [ADDR_W-1:0] done_addr_i,
   output logic [ADDR_W-1:0] ref_o,
   output logic              ref_ok_o
);
   logic [ADDR_W-1:0] ref_q;
   logic              ok_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= '0;
         ok_q  <= 1'b0;
      end else if (done_i) begin
         ref_q <= done_addr_i;
         ok_q  <= 1'b1;
      end
   end

   // A send finishing at this very edge already counts for a new branch.
   assign ref_o    = done_i ? done_addr_i : ref_q;
   assign ref_ok_o = done_i | ok_q;
endmodule

// File: rtl/trc_seq.sv
module trc_seq
   import trc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  span_e             start_span_i,
   output logic [3:0]        data_o,
   output logic              sync_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] cur_addr_o
);
   localparam int MAX_NIB = ADDR_W / NIB_W;
   localparam int CNT_W   = $clog2(MAX_NIB + 1);

   logic              busy_q;
   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] shr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        data_q;
   logic              sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
         shr_q  <= '0;
         addr_q <= '0;
         data_q <= IDLE_NIB;
         sync_q <= 1'b1;
      end else if (start_i) begin
         busy_q <= 1'b1;
         left_q <= CNT_W'(span_nibs(start_span_i));
         shr_q  <= start_addr_i;
         addr_q <= start_addr_i;
         data_q <= {HDR_TAG, start_span_i};
         sync_q <= 1'b0;
      end else if (busy_q) begin
         if (left_q != '0) begin
            data_q <= shr_q[NIB_W-1:0];
            shr_q  <= shr_q >> NIB_W;
            left_q <= left_q - 1'b1;
         end else begin
            busy_q <= 1'b0;
            data_q <= IDLE_NIB;
            sync_q <= 1'b1;
         end
      end
   end

   assign done_o     = busy_q && (left_q == '0);
   assign data_o     = data_q;
   assign sync_o     = sync_q;
   assign cur_addr_o = addr_q;
endmodule

// File: rtl/trc_serializer.sv
module trc_serializer
   import trc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              trc_clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic [ADDR_W-1:0] br_addr,
   output logic [3:0]        tr_data,
   output logic              tr_sync
);
   if (ADDR_W != (NIB_W << 3)) begin : g_bad_width
      $error("trc_serializer: ADDR_W must be eight nibbles wide");
   end

   logic [ADDR_W-1:0] ref_addr_w;
   logic              ref_ok_w;
   logic [ADDR_W-1:0] cur_addr_w;
   logic              done_w;
   span_e             span_w;

   trc_ref #(.ADDR_W(ADDR_W)) u_ref (
      .clk         (trc_clk),
      .rst_n       (rst_n),
      .done_i      (done_w),
      .done_addr_i (cur_addr_w),
      .ref_o       (ref_addr_w),
      .ref_ok_o    (ref_ok_w)
   );

   trc_len_sel #(.ADDR_W(ADDR_W)) u_len (
      .addr_i   (br_addr),
      .ref_i    (ref_addr_w),
      .ref_ok_i (ref_ok_w),
      .span_o   (span_w)
   );

   trc_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk          (trc_clk),
      .rst_n        (rst_n),
      .start_i      (br_valid),
      .start_addr_i (br_addr),
      .start_span_i (span_w),
      .data_o       (tr_data),
      .sync_o       (tr_sync),
      .done_o       (done_w),
      .cur_addr_o   (cur_addr_w)
   );
endmodule

// File: rtl/trc_serializer_chk.sv
module trc_serializer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       br_valid,
   input logic [3:0] tr_data,
   input logic       tr_sync,
   input logic       seq_done
);
   logic sent_once;

   always_ff @(posedge clk) begin
      if (!rst_n)        sent_once <= 1'b0;
      else if (seq_done) sent_once <= 1'b1;
   end

   AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      tr_sync |-> tr_data == 4'b0011);                                   // R1

   AST_HDR_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |=> (!tr_sync && tr_data[3:2] == 2'b10));                  // R3

   AST_SYNC_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tr_sync) |-> $past(br_valid));                                // R9

   AST_FIRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !sent_once && !seq_done) |=> tr_data == 4'b1011);      // R6
endmodule

bind trc_serializer trc_serializer_chk u_chk (
   .clk      (trc_clk),
   .rst_n    (rst_n),
   .br_valid (br_valid),
   .tr_data  (tr_data),
   .tr_sync  (tr_sync),
   .seq_done (done_w)
);

// File: tb/trc_serializer_test.sv
module trc_serializer_test;
   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid = 1'b0;
   logic [31:0] br_addr = '0;
   logic [3:0]  tr_data;
   logic        tr_sync;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic [31:0] m_ref = '0;
   bit          m_ok  = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trc_serializer uut (
      .trc_clk  (clk),
      .rst_n    (rst_n),
      .br_valid (br_valid),
      .br_addr  (br_addr),
      .tr_data  (tr_data),
      .tr_sync  (tr_sync)
   );

   task automatic chk_nib(input string req, input logic [3:0] got, input logic [3:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: tr_data=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic chk_sync(input string req, input logic got, input logic exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: tr_sync=%b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   // Model of R5/R6: shortest length whose dropped upper bits match the reference.
   function automatic int exp_span(input logic [31:0] a);
      if (!m_ok) return 3;
      for (int s = 0; s < 3; s++) begin
         int lo = 4 << s;
         if ((a >> lo) == (m_ref >> lo)) return s;
      end
      return 3;
   endfunction

   task automatic launch(input logic [31:0] a);
      br_valid = 1'b1;
      br_addr  = a;
   endtask

   task automatic expect_stream(input logic [31:0] a, input int sp, input int n_chk);
      logic [1:0] code = 2'(sp);
      @(negedge clk);
      br_valid = 1'b0;
      chk_nib("R2/R3 header", tr_data, {2'b10, code});
      chk_sync("R9 sync low on header", tr_sync, 1'b0);
      for (int i = 0; i < n_chk; i++) begin
         @(negedge clk);
         chk_nib("R4 nibble order", tr_data, a[i*4 +: 4]);
         chk_sync("R9 sync low on nibble", tr_sync, 1'b0);
      end
   endtask

   task automatic expect_idle();
      @(negedge clk);
      chk_nib("R1 idle pattern", tr_data, 4'b0011);
      chk_sync("R9 sync high after send", tr_sync, 1'b1);
   endtask

   task automatic send_full(input logic [31:0] a);
      int sp = exp_span(a);
      launch(a);
      expect_stream(a, sp, 1 << sp);
      expect_idle();
      m_ref = a;
      m_ok  = 1'b1;
   endtask

   // Branch b pre-empts a after j+1 address nibbles (j = -1: during the header). R7, R8, R10
   task automatic send_preempt(input logic [31:0] a, input logic [31:0] b, input int j);
      int spa = exp_span(a);
      int spb;
      launch(a);
      expect_stream(a, spa, j + 1);
      if (j + 1 == (1 << spa)) begin
         m_ref = a;
         m_ok  = 1'b1;
      end
      spb = exp_span(b);
      launch(b);
      expect_stream(b, spb, 1 << spb);
      expect_idle();
      m_ref = b;
      m_ok  = 1'b1;
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) begin
         @(negedge clk);
         chk_nib("R1 idle after reset", tr_data, 4'b0011);
         chk_sync("R1 sync high after reset", tr_sync, 1'b1);
      end
   endtask

   task automatic test_first_full();
      // R6: no reference yet, header must be 1011 with 8 nibbles
      send_full(32'h1234_5678);
   endtask

   task automatic test_lengths();
      send_full(32'h1234_5679);   // R5: one nibble, header 1000
      send_full(32'h1234_56A0);   // R5: two nibbles, header 1001
      send_full(32'h1234_BEEF);   // R5: four nibbles, header 1010
      send_full(32'hCAFE_0000);   // R5: full, header 1011
      send_full(32'hCAFE_0000);   // R5: identical address still sends one nibble
   endtask

   task automatic test_preempt_mid();
      // R7/R8: cut-short send is not the reference, so b compresses to one nibble
      send_preempt(32'h0BAD_F00D, 32'hCAFE_0001, 2);
   endtask

   task automatic test_preempt_last();
      // R10: branch on the last-nibble edge, the interrupted send counts as complete
      send_preempt(32'hCAFE_1234, 32'hCAFE_1235, 3);
   endtask

   task automatic test_preempt_header();
      // R8: pre-empt during the header, reference stays at CAFE1235
      send_preempt(32'h0000_0000, 32'hCAFE_1230, -1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      test_reset();
      @(negedge clk);
      test_first_full();
      test_lengths();
      test_preempt_mid();
      test_preempt_last();
      test_preempt_header();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(CLK_P * 100000);
      vectors++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end
endmodule